// File: doc/BRIEF.md
# Deferred Coprocessor Error Trap

This block sits between an instruction issue stage and a floating-point coprocessor that reports faults late. When the coprocessor signals an exception whose mask bit is clear, the exception bits are recorded as sticky pending flags and an active-low fault line is pulled low. The fault is not acted on when it is recorded. The issue side only looks at the line when an instruction is about to issue.

Each issue request carries a class tag. Integer instructions and no-wait floating-point instructions always issue. A waiting floating-point instruction, which includes a plain wait, is held back while the fault line is low. In that case the block emits a one-cycle trap request carrying a fixed vector, 16 by default. A handler then removes the fault, either with an explicit flush command or with a state store that also scrubs. A plain store only copies out the pending flags. After the fault is gone, the held instruction is presented again and issues.

Top module: `fpe_defer_trap`

## Requirements
- R1: An exception event (`exc_vld`=1) with at least one bit set in `exc_bits & ~exc_mask` drives `fault_l` low from the next cycle, and those bits become pending.
- R2: Exception bits whose mask bit is 1 are never recorded. A fully masked event leaves `fault_l` high when nothing is pending.
- R3: A waiting floating-point request (class code 1) gets `issue_grant`=1 on the next cycle when `fault_l` is high. It gets no grant when `fault_l` is low.
- R4: A waiting floating-point request seen while `fault_l` is low produces `trap_req`=1 on the next cycle, with `trap_vec` equal to 16. `trap_vec` is 0 whenever `trap_req` is 0.
- R5: A no-wait floating-point request (class code 2, and also code 3) is granted on the next cycle even while `fault_l` is low. It raises no trap, and `fault_l` stays low.
- R6: A store (`store_cmd`=1) gives `store_vld`=1 on the next cycle, with `store_bits` equal to the pending flags before the command. With `store_wipe`=1 the flags are cleared and `fault_l` is high from the next cycle. With `store_wipe`=0 the flags and `fault_l` are unchanged.
- R7: An integer request (class code 0) is granted on the next cycle whatever the state of `fault_l`.
- R8: Pending flags are sticky. New unmasked bits are ORed in. `flush_cmd` clears them and sets `fault_l` high from the next cycle. Bits that arrive in the same cycle as a flush survive it.
- R9: `trap_req` is a one-cycle pulse. After a trap, further waiting requests raise no trap until a flush or a scrubbing store occurs. A request arriving in the same cycle as a flush or scrubbing store is neither granted nor trapped.
- R10: After reset, `fault_l`=1 and `issue_grant`, `trap_req`, `trap_vec` and `store_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_vld | input | 1 | Exception event strobe |
| exc_bits | input | NUM_EXC | Exception bits raised by the event |
| exc_mask | input | NUM_EXC | Mask per bit, 1 = masked |
| flush_cmd | input | 1 | Clear pending exceptions |
| store_cmd | input | 1 | Copy out pending state |
| store_wipe | input | 1 | With store_cmd: clear after copying |
| issue_req | input | 1 | An instruction is about to issue |
| issue_cls | input | 2 | Class: 0 integer, 1 waiting FP, 2 or 3 no-wait FP |
| fault_l | output | 1 | Active-low pending-fault line |
| issue_grant | output | 1 | Request was allowed to issue |
| trap_req | output | 1 | One-cycle trap request |
| trap_vec | output | VEC_W | Trap vector, valid with trap_req |
| store_vld | output | 1 | Stored state valid |
| store_bits | output | NUM_EXC | Stored pending flags |

## Verification
On every cycle, the assertions check several input-to-output relations. Unmasked events pull the line low and masked-only events on a clean state leave it high. Flushes release the line, and integer and no-wait requests are always granted. A trap never comes with a grant, is never longer than one cycle, and stores always answer. The bench's scenarios are the only way to show three things. The first is that a second trap stays suppressed for the same pending fault and re-arms only after a clear. The second is that the copied-out flags match the OR of every earlier unmasked event. The third is the ordering when a flush and a new event land in the same cycle.

// File: rtl/fdt_pkg.sv
package fdt_pkg;
  typedef enum logic [1:0] {
    CLS_INT     = 2'd0,
    CLS_FP_WAIT = 2'd1,
    CLS_FP_NOW  = 2'd2,
    CLS_FP_NOW2 = 2'd3
  } issue_cls_e;
endpackage

// File: rtl/fdt_flags.sv
module fdt_flags #(
  parameter int NUM_EXC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exc_vld,
  input  logic [NUM_EXC-1:0] exc_bits,
  input  logic [NUM_EXC-1:0] exc_mask,
  input  logic               wipe,
  output logic [NUM_EXC-1:0] flags,
  output logic               fault_l
);
  logic [NUM_EXC-1:0] fresh;
  logic [NUM_EXC-1:0] nxt;

  // Only unmasked bits are recorded; a wipe clears old bits but keeps fresh ones.
  assign fresh = exc_vld ? (exc_bits & ~exc_mask) : '0;
  assign nxt   = (wipe ? '0 : flags) | fresh;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      fault_l <= 1'b1;
    end else begin
      flags   <= nxt;
      fault_l <= ~|nxt;
    end
  end

  assert_unmasked_low_R1: assert property (@(posedge clk) disable iff (rst)
    (exc_vld && |(exc_bits & ~exc_mask)) |=> !fault_l);

  assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (exc_vld && !(|(exc_bits & ~exc_mask)) && fault_l) |=> fault_l);

  assert_flush_release_R8: assert property (@(posedge clk) disable iff (rst)
    (wipe && !exc_vld) |=> fault_l);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (!wipe && !fault_l) |=> !fault_l);
endmodule

// File: rtl/fdt_snap.sv
module fdt_snap #(
  parameter int NUM_EXC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               store_cmd,
  input  logic [NUM_EXC-1:0] flags,
  output logic               snap_vld,
  output logic [NUM_EXC-1:0] snap_bits
);
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_vld  <= 1'b0;
      snap_bits <= '0;
    end else begin
      snap_vld <= store_cmd;
      if (store_cmd) snap_bits <= flags;
    end
  end

  assert_store_answers_R6: assert property (@(posedge clk) disable iff (rst)
    store_cmd |=> snap_vld);

  assert_store_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !store_cmd |=> !snap_vld);
endmodule

// File: rtl/fdt_gate.sv
module fdt_gate #(
  parameter int VEC_W    = 8,
  parameter int TRAP_VEC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [1:0]       cls,
  input  logic             fault_l,
  input  logic             rearm,
  output logic             grant,
  output logic             trap,
  output logic [VEC_W-1:0] vec
);
  import fdt_pkg::*;

  localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(TRAP_VEC);

  issue_cls_e cls_e;
  logic       is_wait;
  logic       blocked;
  logic       fire;
  logic       spent;

  assign cls_e   = issue_cls_e'(cls);
  assign is_wait = req && (cls_e == CLS_FP_WAIT);
  // Held back when the fault is pending or a clear is landing this cycle.
  assign blocked = is_wait && (!fault_l || rearm);
  assign fire    = is_wait && !fault_l && !spent && !rearm;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= 1'b0;
      trap  <= 1'b0;
      vec   <= '0;
      spent <= 1'b0;
    end else begin
      grant <= req && !blocked;
      trap  <= fire;
      vec   <= fire ? VEC_VAL : '0;
      spent <= rearm ? 1'b0 : (spent | fire);
    end
  end

  assert_int_grant_R7: assert property (@(posedge clk) disable iff (rst)
    (req && cls == 2'd0) |=> grant);

  assert_nowait_grant_R5: assert property (@(posedge clk) disable iff (rst)
    (req && cls[1]) |=> (grant && !trap));

  assert_trap_no_grant_R4: assert property (@(posedge clk) disable iff (rst)
    trap |-> !grant);

  assert_trap_vec_R4: assert property (@(posedge clk) disable iff (rst)
    trap |-> (vec == VEC_VAL));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    trap |=> !trap);
endmodule

// File: rtl/fpe_defer_trap.sv
module fpe_defer_trap #(
  parameter int NUM_EXC  = 6,
  parameter int VEC_W    = 8,
  parameter int TRAP_VEC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exc_vld,
  input  logic [NUM_EXC-1:0] exc_bits,
  input  logic [NUM_EXC-1:0] exc_mask,
  input  logic               flush_cmd,
  input  logic               store_cmd,
  input  logic               store_wipe,
  input  logic               issue_req,
  input  logic [1:0]         issue_cls,
  output logic               fault_l,
  output logic               issue_grant,
  output logic               trap_req,
  output logic [VEC_W-1:0]   trap_vec,
  output logic               store_vld,
  output logic [NUM_EXC-1:0] store_bits
);
  logic               wipe;
  logic [NUM_EXC-1:0] flags;

  assign wipe = flush_cmd | (store_cmd & store_wipe);

  fdt_flags #(.NUM_EXC(NUM_EXC)) u_flags (
    .clk(clk), .rst(rst), .exc_vld(exc_vld), .exc_bits(exc_bits),
    .exc_mask(exc_mask), .wipe(wipe), .flags(flags), .fault_l(fault_l)
  );

  fdt_snap #(.NUM_EXC(NUM_EXC)) u_snap (
    .clk(clk), .rst(rst), .store_cmd(store_cmd), .flags(flags),
    .snap_vld(store_vld), .snap_bits(store_bits)
  );

  fdt_gate #(.VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)) u_gate (
    .clk(clk), .rst(rst), .req(issue_req), .cls(issue_cls),
    .fault_l(fault_l), .rearm(wipe), .grant(issue_grant),
    .trap(trap_req), .vec(trap_vec)
  );

  assert_plain_store_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (store_cmd && !store_wipe && !flush_cmd && !fault_l) |=> !fault_l);
endmodule

// File: tb/sim_fpe_defer_trap.sv
module sim_fpe_defer_trap;
  localparam int CLK_PER = 10;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exc_vld = 1'b0;
  logic [N-1:0] exc_bits = '0, exc_mask = '0;
  logic flush_cmd = 1'b0, store_cmd = 1'b0, store_wipe = 1'b0;
  logic issue_req = 1'b0;
  logic [1:0] issue_cls = 2'd0;
  logic fault_l, issue_grant, trap_req, store_vld;
  logic [7:0] trap_vec;
  logic [N-1:0] store_bits;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  fpe_defer_trap #(.NUM_EXC(N), .VEC_W(8), .TRAP_VEC(16)) u0 (
    .clk(clk), .rst(rst), .exc_vld(exc_vld), .exc_bits(exc_bits),
    .exc_mask(exc_mask), .flush_cmd(flush_cmd), .store_cmd(store_cmd),
    .store_wipe(store_wipe), .issue_req(issue_req), .issue_cls(issue_cls),
    .fault_l(fault_l), .issue_grant(issue_grant), .trap_req(trap_req),
    .trap_vec(trap_vec), .store_vld(store_vld), .store_bits(store_bits)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    exc_vld = 0; exc_bits = '0; exc_mask = '0; flush_cmd = 0;
    store_cmd = 0; store_wipe = 0; issue_req = 0; issue_cls = 2'd0;
  endtask

  // Inputs set 1 time unit after a rising edge; outputs sampled at the same offset.
  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_flush();
    flush_cmd = 1; tick();
  endtask

  task automatic do_exc(input logic [N-1:0] b, input logic [N-1:0] m);
    exc_vld = 1; exc_bits = b; exc_mask = m; tick();
  endtask

  task automatic do_issue(input logic [1:0] c);
    issue_req = 1; issue_cls = c; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R10 reset state
    chk("R10 fault_l", fault_l, 1);
    chk("R10 grant", issue_grant, 0);
    chk("R10 trap", trap_req, 0);
    chk("R10 vec", trap_vec, 0);
    chk("R10 store_vld", store_vld, 0);

    // R1/R2 exhaustive over bits and mask; plain store must copy and keep (R6)
    for (int e = 0; e < 8; e++) begin
      for (int m = 0; m < 8; m++) begin
        int exp_bits;
        exp_bits = e & ~m & 7;
        do_flush();
        do_exc(N'(e), N'(m));
        chk(exp_bits != 0 ? "R1 fault after event" : "R2 masked quiet",
            fault_l, exp_bits != 0 ? 0 : 1);
        store_cmd = 1; tick();
        chk("R6 plain store vld", store_vld, 1);
        chk("R6 plain store bits", store_bits, exp_bits);
        chk("R6 plain store keeps fault", fault_l, exp_bits != 0 ? 0 : 1);
      end
    end

    // R3/R4/R5/R7/R9 class sweep with and without pending fault
    for (int f = 0; f < 2; f++) begin
      for (int c = 0; c < 4; c++) begin
        bit blk;
        blk = (f == 1) && (c == 1);
        do_flush();
        if (f == 1) do_exc(3'b001, 3'b000);
        do_issue(2'(c));
        if (c == 0) chk("R7 int grant", issue_grant, 1);
        else if (c == 1) chk("R3 wait grant", issue_grant, blk ? 0 : 1);
        else chk("R5 nowait grant", issue_grant, 1);
        chk("R4 trap", trap_req, blk ? 1 : 0);
        chk("R4 vec", trap_vec, blk ? 16 : 0);
        if (c >= 2) chk("R5 fault stays", fault_l, f == 1 ? 0 : 1);
        if (blk) begin
          do_issue(2'd1);
          chk("R9 no repeat trap", trap_req, 0);
          chk("R9 still held", issue_grant, 0);
        end
      end
    end

    // R8 sticky OR, scrubbing store (R6), rearm after clear (R9)
    do_flush();
    do_exc(3'b001, 3'b000);
    do_exc(3'b110, 3'b100);
    do_issue(2'd1);
    chk("R4 trap sticky", trap_req, 1);
    store_cmd = 1; store_wipe = 1; tick();
    chk("R8 sticky bits", store_bits, 3);
    chk("R6 scrub releases", fault_l, 1);
    do_issue(2'd1);
    chk("R9 reissue after scrub", issue_grant, 1);
    do_exc(3'b100, 3'b000);
    do_issue(2'd1);
    chk("R9 rearmed trap", trap_req, 1);
    do_flush();
    chk("R8 flush releases", fault_l, 1);
    do_issue(2'd1);
    chk("R9 reissue after flush", issue_grant, 1);

    // R8 flush and event in the same cycle: event survives
    do_exc(3'b001, 3'b000);
    flush_cmd = 1; exc_vld = 1; exc_bits = 3'b010; tick();
    chk("R8 same-cycle fault", fault_l, 0);
    store_cmd = 1; tick();
    chk("R8 same-cycle bits", store_bits, 2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule